// File: doc/BRIEF.md
# Reload-Divided 8-bit PWM Channel

This block is a single pulse-width-modulated output that is set up through one 32-bit control word. The control word carries an enable flag, an 8-bit reload code and an 8-bit duty code. The reload code divides the input clock. Each divided tick advances an 8-bit phase counter, and the counter wraps after 256 steps, which sets the output period.

The duty code sets the part of each period during which the output is low. The high level comes first in the period and lasts for the rest of it. A small duty code therefore gives a mostly-high waveform. A duty code of zero keeps the line low.

A control word written while the channel runs is held aside. It is applied only when the phase counter wraps, so the output never shows a partial or mixed period. Clearing the enable flag stops the channel at once. The next enable then starts a fresh period.

Top module: `pwm8_channel`

## Requirements
- R1: The control word is decoded as bit 31 = enable, bits 15:8 = reload code, bits 7:0 = duty code. Bits 30:16 have no effect, and a word with bit 31 clear leaves the output low whatever the other fields hold.
- R2: A reload code from 1 to 255 makes the phase counter advance once every "code" input clock cycles.
- R3: A reload code of 0 makes the phase counter advance once every 256 input clock cycles.
- R4: The output period is 256 × divisor input clock cycles. The first sample of every following period is high when the duty code is nonzero.
- R5: For a duty code d from 1 to 255, the output is high for the first (256 − d) × divisor cycles of each period and low for the remaining d × divisor cycles.
- R6: A duty code of 0 keeps the output low for the whole time the channel is enabled.
- R7: The output is low from the second clock edge after a write that clears the enable. A later enabling write starts the period at phase 0, with the output valid from the second clock edge after that write.
- R8: A control word written while the channel runs takes effect only at the next wrap of the phase counter. The period that is in progress completes with the old reload and duty values.
- R9: After reset the enable is clear and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, which is divided by the reload code |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value taken when wr_en is high |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a control word that arrives partway through a period, because the held-aside value must stay invisible until the phase counter wraps. To reach it, the stimulus starts a fresh period, opens one long measurement window, and writes a different duty code ten cycles into that window. The expected high count and the position of the first falling edge are then built from the old duty for the first period and the new duty for the second. Every other case begins with a disable and a re-enable, so each window starts at phase 0. This alignment also exposes a counter that is not cleared by the disable.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  parameter int DIV_W      = 8;
  parameter int PH_W       = 8;
  parameter int WORD_W     = 32;
  parameter int EN_POS     = 31;
  parameter int RELOAD_LSB = 8;
  parameter int DUTY_LSB   = 0;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] reload;
    logic [PH_W-1:0]  duty;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm8_divider.sv
module pwm8_divider #(
  parameter int W = pwm8_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_n;
  logic [W-1:0] last_val;
  logic         terminal;

  // A code of 0 wraps to all ones, so the count covers 2**W cycles
  assign last_val = reload - 1'b1;
  assign terminal = (cnt_q == last_val);
  assign tick     = run & terminal;

  always_comb begin
    cnt_n = cnt_q;
    if (!run)          cnt_n = '0;
    else if (terminal) cnt_n = '0;
    else               cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_val);
  a_r7_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm8_phase.sv
module pwm8_phase #(
  parameter int W = pwm8_pkg::PH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] duty,
  output logic         wrap,
  output logic         high
);
  localparam logic [W:0] FULL = 1 << W;

  logic [W-1:0] phase_q, phase_n;
  logic [W:0]   thresh;

  assign wrap   = tick & (phase_q == {W{1'b1}});
  assign thresh = FULL - {1'b0, duty};
  assign high   = run & (duty != '0) & ({1'b0, phase_q} < thresh);

  always_comb begin
    phase_n = phase_q;
    if (!run)      phase_n = '0;
    else if (tick) phase_n = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  a_r4_phase_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
  import pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pwm_out
);
  logic [1:0] rs_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  // Written control word
  pwm_cfg_t ctrl_q, ctrl_n;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en) begin
      ctrl_n.en     = wr_data[EN_POS];
      ctrl_n.reload = wr_data[RELOAD_LSB +: DIV_W];
      ctrl_n.duty   = wr_data[DUTY_LSB +: PH_W];
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_n;
  end

  // Active settings, loaded at start and at each period wrap
  logic             run_q, run_n;
  logic [DIV_W-1:0] act_reload_q, act_reload_n;
  logic [PH_W-1:0]  act_duty_q, act_duty_n;
  logic             tick, wrap, high;

  always_comb begin
    run_n        = run_q;
    act_reload_n = act_reload_q;
    act_duty_n   = act_duty_q;
    if (!ctrl_q.en) begin
      run_n = 1'b0;
    end else if (!run_q || wrap) begin
      run_n        = 1'b1;
      act_reload_n = ctrl_q.reload;
      act_duty_n   = ctrl_q.duty;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      run_q        <= 1'b0;
      act_reload_q <= '0;
      act_duty_q   <= '0;
    end else begin
      run_q        <= run_n;
      act_reload_q <= act_reload_n;
      act_duty_q   <= act_duty_n;
    end
  end

  pwm8_divider #(.W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .run    (run_q),
    .reload (act_reload_q),
    .tick   (tick)
  );

  pwm8_phase #(.W(PH_W)) u_phase (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (run_q),
    .tick  (tick),
    .duty  (act_duty_q),
    .wrap  (wrap),
    .high  (high)
  );

  assign pwm_out = high;

  a_r7_off_goes_low: assert property (@(posedge clk) disable iff (!core_rst_n)
    !ctrl_q.en |=> !pwm_out);
  a_r8_cfg_held_mid_period: assert property (@(posedge clk) disable iff (!core_rst_n)
    (run_q && !wrap) |=> ($stable(act_duty_q) && $stable(act_reload_q)));
  a_r5_period_starts_high: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($rose(run_q) && (act_duty_q != '0)) |-> pwm_out);
  a_r9_reset_low: assert property (@(posedge clk) disable iff (!core_rst_n)
    !run_q |-> !pwm_out);
endmodule

// File: tb/tb_pwm8_channel.sv
`timescale 1ns/1ps
module tb_pwm8_channel;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        pwm_out;

  int tests_run;
  int tests_failed;

  typedef struct {
    int    win;
    int    exp_high;
    int    exp_fall;
    string tag;
  } item_t;

  item_t q[$];
  int    pushed;
  int    done;

  pwm8_channel dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor: measures each window from its first negedge sample
  initial begin
    item_t cur;
    bit    active;
    int    idx, hc, fall;
    bit    prev;
    active = 0; idx = 0; hc = 0; fall = -1; prev = 0;
    forever begin
      @(negedge clk);
      if (!active && q.size() > 0) begin
        cur = q.pop_front();
        active = 1; idx = 0; hc = 0; fall = -1; prev = 0;
      end
      if (active) begin
        if (pwm_out) hc++;
        if (!pwm_out && prev && fall < 0) fall = idx;
        prev = pwm_out;
        idx++;
        if (idx == cur.win) begin
          tests_run++;
          if (hc != cur.exp_high) begin
            tests_failed++;
            $display("FAIL %s high count: actual %0d expected %0d", cur.tag, hc, cur.exp_high);
          end
          tests_run++;
          if (fall != cur.exp_fall) begin
            tests_failed++;
            $display("FAIL %s first fall index: actual %0d expected %0d", cur.tag, fall, cur.exp_fall);
          end
          active = 0;
          done++;
        end
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic push_item(input int win, input int h, input int f, input string tag);
    item_t it;
    #1;
    it.win = win; it.exp_high = h; it.exp_fall = f; it.tag = tag;
    q.push_back(it);
    pushed++;
  endtask

  task automatic wait_done();
    wait (done == pushed);
  endtask

  // Fresh period: disable, then enable with word d; window covers one period plus one sample
  task automatic run_case(input logic [31:0] d, input int div, input int duty, input string tag);
    int h;
    wr(32'h0);
    repeat (2) @(negedge clk);
    wr(d);
    h = (duty == 0) ? 0 : (256 - duty) * div + 1;
    push_item(256 * div + 1, h, (duty == 0) ? -1 : (256 - duty) * div, tag);
    wait_done();
  endtask

  initial begin
    #(200000 * 20);
    tests_failed++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    tests_run = 0; tests_failed = 0; pushed = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    tests_run++;
    if (pwm_out !== 1'b0) begin
      tests_failed++;
      $display("FAIL R9 output after reset: actual %b expected 0", pwm_out);
    end
    push_item(20, 0, -1, "R9");
    wait_done();

    // R2 R5: divide by 1, several duty codes
    run_case(32'h8000_0180, 1, 128, "R2/R5 d128");
    run_case(32'h8000_0101, 1, 1,   "R5 d1");
    run_case(32'h8000_01FF, 1, 255, "R5 d255");
    // R2 R4: divide by 3
    run_case(32'h8000_0364, 3, 100, "R2/R4 r3");
    // R6: duty 0 stays low
    run_case(32'h8000_0100, 1, 0, "R6 d0");
    // R3 R4: reload 0 divides by 256
    run_case(32'h8000_00C0, 256, 192, "R3/R4 r0");

    // R8: mid-period write takes effect at the wrap
    wr(32'h0);
    repeat (2) @(negedge clk);
    wr(32'h8000_0180);
    push_item(513, 128 + 64 + 1, 128, "R8 boundary");
    repeat (10) @(negedge clk);
    wr(32'h8000_01C0);
    wait_done();

    // R7: disable drives the output low
    wr(32'h8000_0180);
    repeat (40) @(negedge clk);
    wr(32'h0000_0180);
    push_item(600, 0, -1, "R7 disable");
    wait_done();

    // R1 R7: junk in bits 30:16 ignored, re-enable starts at phase 0
    wr(32'hFFFF_0240);
    push_item(513, 192 * 2 + 1, 192 * 2, "R1/R7 reenable");
    wait_done();

    // R1: enable bit clear keeps output low regardless of fields
    wr(32'h0);
    repeat (2) @(negedge clk);
    wr(32'h7FFF_0180);
    push_item(600, 0, -1, "R1 en clear");
    wait_done();

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule